// File: doc/BRIEF.md
# Cycle-by-Cycle Peak Current Limiter with Over-Current Shutdown

This block is the digital half of a peak-current guard for a switching power converter. An analog comparator outside the block compares the sensed switch current against a trip level. The block supplies that level as a 4-bit code and the comparator's hysteresis as a 2-bit code. The comparator's raw output comes back asynchronously. The block passes it through a two-stage synchronizer. It then ignores the result during a leading-edge blanking window that opens at each switching-cycle start marker from the PWM generator. A trip outside the window raises a terminate request. The request tells the PWM generator to end the active gate drive for the rest of that switching cycle.

At every cycle boundary the block checks whether the cycle that just ended was limited. It counts such cycles in an unbroken run. When the run length reaches a programmed limit, it latches an over-current shutdown with no processor involvement and pulses an interrupt. The latch holds until software writes a clear bit, disables the block, or reset is applied. A small synchronous register port holds the enable, blanking selection, trip and hysteresis codes and the run limit, and reports the shutdown state.

Top module: `ilim_guard`

## Requirements
- R1: After synchronous reset, term_o, shut_o and irq_o are 0, thr_code and hyst_code are 0, and every register reads 0.
- R2: A write to address 1 places wdata[3:0] on thr_code and wdata[5:4] on hyst_code from the next cycle on. Address 1 reads back as {2'b00, hyst, thr}.
- R3: With blanking closed, a rising comparator input reaches the synchronized trip after two clock edges, and term_o rises on the third edge.
- R4: The blanking code in control bits [2:1] is 0, 1, 2 or 3 and selects N = 0, 4, 8 or 16 cycles. With the comparator already high, term_o is still 0 N edges after the start edge and is 1 after N+1 edges.
- R5: A comparator pulse that ends inside the blanking window never raises term_o in that cycle. The same pulse after the window does raise it.
- R6: Once raised, term_o stays high after the comparator falls, and it is cleared on the clock edge that samples cyc_start.
- R7: On each cyc_start edge the run counter increments if term_o was high. When the new count equals the nonzero limit at address 2, shut_o and irq_o rise on that edge, and irq_o lasts exactly one cycle.
- R8: A switching cycle that ends with term_o low resets the run counter to zero.
- R9: shut_o is sticky. Writing address 0 with bit 3 set clears it on that edge. Status address 3 bit 0 reports it. The run count restarts from zero after a clear.
- R10: A limit of 0 never shuts down. The run counter stops at its all-ones value, so a later limit equal to all-ones trips on the next limited boundary.
- R11: Control bit 0 is the enable. With it at 0, term_o and shut_o are low from the second edge after the write, the shutdown latch and counter are cleared, and comparator trips have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output, high when current is above the trip level |
| cyc_start | input | 1 | One-cycle marker at the start of each switching cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 level, 2 limit, 3 status |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr (combinational) |
| thr_code | output | 4 | Trip level code to the threshold DAC |
| hyst_code | output | 2 | Hysteresis code to the comparator |
| term_o | output | 1 | Terminate request for the rest of the current switching cycle |
| shut_o | output | 1 | Latched over-current shutdown |
| irq_o | output | 1 | One-cycle interrupt when shutdown latches |

## Verification
The bench builds the block with a 4-bit run counter instead of the default 8 bits. This makes the saturation at all-ones reachable in a handful of switching cycles, so the wrap-versus-hold difference shows at the shutdown output once the limit is raised to 15. All four blanking codes are exercised with a continuously high comparator, which pins the exact edge at which the terminate request appears for windows of 0, 4, 8 and 16 cycles. A limit of 3 with a clean cycle inserted in the run covers the consecutive-only counting.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
    localparam int unsigned CFG_AW = 2;
    localparam int unsigned CFG_DW = 8;
    localparam int unsigned THR_W  = 4;
    localparam int unsigned HYS_W  = 2;
    localparam int unsigned BSEL_W = 2;

    localparam logic [CFG_AW-1:0] ADR_CTRL  = 2'd0;
    localparam logic [CFG_AW-1:0] ADR_LEVEL = 2'd1;
    localparam logic [CFG_AW-1:0] ADR_LIMIT = 2'd2;
    localparam logic [CFG_AW-1:0] ADR_STAT  = 2'd3;

    localparam int unsigned CTRL_EN  = 0;
    localparam int unsigned CTRL_BLO = 1;
    localparam int unsigned CTRL_CLR = 3;

    typedef struct packed {
        logic              en;
        logic [BSEL_W-1:0] blk;
        logic [THR_W-1:0]  thr;
        logic [HYS_W-1:0]  hyst;
    } ilim_cfg_t;

    // blanking length in clocks: 0, 4, 8, 16
    function automatic int unsigned blank_len(input logic [BSEL_W-1:0] code);
        if (code == '0) return 0;
        return 32'd2 << code;
    endfunction

    localparam int unsigned BLK_MAX = 16;
endpackage

// File: rtl/ilim_sync.sv
module ilim_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ilim_regs.sv
module ilim_regs
    import ilim_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              shut,
    output ilim_cfg_t         cfg,
    output logic [CNT_W-1:0]  limit,
    output logic              clr,
    output logic [CFG_DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            limit <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTRL: begin
                    cfg.en  <= wdata[CTRL_EN];
                    cfg.blk <= wdata[CTRL_BLO +: BSEL_W];
                end
                ADR_LEVEL: begin
                    cfg.thr  <= wdata[THR_W-1:0];
                    cfg.hyst <= wdata[THR_W +: HYS_W];
                end
                ADR_LIMIT: limit <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr = we && (addr == ADR_CTRL) && wdata[CTRL_CLR];

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL:  begin
                rdata[CTRL_EN]             = cfg.en;
                rdata[CTRL_BLO +: BSEL_W]  = cfg.blk;
            end
            ADR_LEVEL: begin
                rdata[THR_W-1:0]      = cfg.thr;
                rdata[THR_W +: HYS_W] = cfg.hyst;
            end
            ADR_LIMIT: rdata = CFG_DW'(limit);
            default:   rdata[0] = shut;
        endcase
    end
endmodule

// File: rtl/ilim_window.sv
module ilim_window
    import ilim_pkg::*;
#(
    parameter int unsigned BLK_W = $clog2(BLK_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic              cmp_s,
    input  logic [BSEL_W-1:0] blk_code,
    output logic              term
);
    logic [BLK_W-1:0] blank_q;
    logic             open_w;

    assign open_w = (blank_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            blank_q <= '0;
            term    <= 1'b0;
        end else if (start) begin
            blank_q <= BLK_W'(blank_len(blk_code));
            term    <= 1'b0;
        end else begin
            if (!open_w)         blank_q <= blank_q - 1'b1;
            if (open_w && cmp_s) term    <= 1'b1;
        end
    end
endmodule

// File: rtl/ilim_track.sv
module ilim_track #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             term,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             shut,
    output logic             irq
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nxt;
    logic             hit;

    assign run_nxt = (run_q == '1) ? run_q : run_q + 1'b1;
    assign hit     = start && term && (limit != '0) && (run_nxt == limit);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q <= '0;
            shut  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= hit && !shut && !clr;
            if (clr)      shut <= 1'b0;
            else if (hit) shut <= 1'b1;
            if (shut || clr) run_q <= '0;
            else if (start)  run_q <= term ? run_nxt : '0;
        end
    end
endmodule

// File: rtl/ilim_guard.sv
module ilim_guard
    import ilim_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_raw,
    input  logic              cyc_start,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic [THR_W-1:0]  thr_code,
    output logic [HYS_W-1:0]  hyst_code,
    output logic              term_o,
    output logic              shut_o,
    output logic              irq_o
);
    ilim_cfg_t        cfg_w;
    logic [CNT_W-1:0] limit_w;
    logic             clr_w;
    logic             cmp_s;
    logic             en_w;

    assign en_w = cfg_w.en;

    ilim_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .shut(shut_o), .cfg(cfg_w), .limit(limit_w), .clr(clr_w), .rdata(cfg_rdata)
    );

    ilim_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(cmp_raw), .q(cmp_s)
    );

    ilim_window u_win (
        .clk(clk), .rst(rst), .en(en_w), .start(cyc_start), .cmp_s(cmp_s),
        .blk_code(cfg_w.blk), .term(term_o)
    );

    ilim_track #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .en(en_w), .start(cyc_start), .term(term_o),
        .clr(clr_w), .limit(limit_w), .shut(shut_o), .irq(irq_o)
    );

    assign thr_code  = cfg_w.thr;
    assign hyst_code = cfg_w.hyst;
endmodule

// File: rtl/ilim_guard_chk.sv
module ilim_guard_chk (
    input logic clk,
    input logic rst,
    input logic cyc_start,
    input logic cmp_s,
    input logic en,
    input logic clr,
    input logic term_o,
    input logic shut_o,
    input logic irq_o
);
    p_trip_synced_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> $past(cmp_s));

    p_term_ends_r6: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !term_o);

    p_irq_on_set_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (shut_o && !$past(shut_o)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(shut_o) |-> ($past(clr) || !en));

    p_disable_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!term_o && !shut_o));
endmodule

bind ilim_guard ilim_guard_chk u_chk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cmp_s(cmp_s), .en(en_w),
    .clr(clr_w), .term_o(term_o), .shut_o(shut_o), .irq_o(irq_o)
);

// File: tb/ilim_guard_bench.sv
module ilim_guard_bench;
    localparam int unsigned CW = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_raw = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [3:0] thr_code;
    logic [1:0] hyst_code;
    logic       term_o, shut_o, irq_o;

    int total = 0;
    int bad = 0;
    logic sh_at_start, irq_at_start, irq_next, term_end;

    always #10 clk = ~clk;

    ilim_guard #(.CNT_W(CW)) u_ilim_guard (
        .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .cyc_start(cyc_start),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .thr_code(thr_code), .hyst_code(hyst_code),
        .term_o(term_o), .shut_o(shut_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // one switching cycle of 11 clocks; comparator high early if trip
    task automatic cyc(input logic trip);
        @(negedge clk);
        cyc_start = 1'b1; cmp_raw = trip;
        @(negedge clk);
        cyc_start = 1'b0;
        sh_at_start = shut_o; irq_at_start = irq_o;
        @(negedge clk);
        irq_next = irq_o;
        repeat (5) @(negedge clk);
        cmp_raw = 1'b0;
        repeat (3) @(negedge clk);
        term_end = term_o;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 term", term_o, 0);
        chk("R1 shut", shut_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 thr", thr_code, 0);
        chk("R1 hyst", hyst_code, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 read", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd1, 8'h2B);
        chk("R2 thr", thr_code, 4'hB);
        chk("R2 hyst", hyst_code, 2'b10);
        rd(2'd1, d);
        chk("R2 readback", d, 8'h2B);
        wr(2'd1, 8'hFF);
        rd(2'd1, d);
        chk("R2 readback masked", d, 8'h3F);
        chk("R2 thr all ones", thr_code, 4'hF);
    endtask

    task automatic t_latency();
        wr(2'd0, 8'h01);
        @(negedge clk);
        cmp_raw = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 term after two edges", term_o, 0);
        @(negedge clk);
        chk("R3 term after three edges", term_o, 1);
        cmp_raw = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 term held", term_o, 1);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk("R6 term cleared at start", term_o, 0);
        repeat (3) @(negedge clk);
        chk("R6 term stays low", term_o, 0);
    endtask

    task automatic t_blank(input int code, input int n);
        wr(2'd0, 8'((code << 1) | 1));
        cmp_raw = 1'b1;
        repeat (3) @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk("R4 term low at start", term_o, 0);
        if (n > 0) begin
            repeat (n) @(negedge clk);
            chk("R4 term low at window end", term_o, 0);
        end
        @(negedge clk);
        chk("R4 term high after window", term_o, 1);
        cmp_raw = 1'b0;
    endtask

    task automatic t_ignore();
        wr(2'd0, 8'h07);
        repeat (4) @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        cmp_raw = 1'b1;
        repeat (4) @(negedge clk);
        cmp_raw = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 blanked pulse ignored", term_o, 0);
        cmp_raw = 1'b1;
        repeat (4) @(negedge clk);
        cmp_raw = 1'b0;
        @(negedge clk);
        chk("R5 same pulse after window trips", term_o, 1);
    endtask

    task automatic t_count();
        logic [7:0] d;
        logic [2:0] seq [6] = '{1, 1, 0, 1, 1, 1};
        logic any_shut = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'd3);
        for (int i = 0; i < 6; i++) begin
            cyc(seq[i][0]);
            any_shut |= sh_at_start;
        end
        chk("R7 trip cycle terminates", term_end, 1);
        chk("R8 clean cycle resets run", any_shut, 0);
        cyc(1'b0);
        chk("R7 shut at third boundary", sh_at_start, 1);
        chk("R7 irq rises", irq_at_start, 1);
        chk("R7 irq one cycle", irq_next, 0);
        cyc(1'b0);
        chk("R9 shut sticky", sh_at_start, 1);
        rd(2'd3, d);
        chk("R9 status bit", d, 1);
        wr(2'd0, 8'h0B);
        chk("R9 clear", shut_o, 0);
        rd(2'd3, d);
        chk("R9 status cleared", d, 0);
        cyc(1'b1);
        cyc(1'b1);
        cyc(1'b0);
        chk("R9 run restarts after clear", sh_at_start, 0);
    endtask

    task automatic t_sat();
        logic any_shut = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'd0);
        for (int i = 0; i < 17; i++) begin
            cyc(1'b1);
            any_shut |= sh_at_start;
        end
        chk("R10 limit zero never shuts", any_shut | shut_o, 0);
        wr(2'd2, 8'd15);
        cyc(1'b0);
        chk("R10 saturated run trips all-ones limit", sh_at_start, 1);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        wr(2'd0, 8'h02);
        @(negedge clk);
        chk("R11 shut forced low", shut_o, 0);
        chk("R11 term forced low", term_o, 0);
        cyc(1'b1);
        chk("R11 trip ignored", term_end, 0);
        chk("R11 no shut while disabled", shut_o, 0);
        wr(2'd0, 8'h03);
        cyc(1'b0);
        chk("R11 latch cleared on reenable", sh_at_start, 0);
        rd(2'd3, d);
        chk("R11 status after reenable", d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_latency();
        t_blank(0, 0);
        t_blank(1, 4);
        t_blank(2, 8);
        t_blank(3, 16);
        t_ignore();
        t_count();
        t_sat();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule